// File: doc/BRIEF.md
# Resistor-Ladder Button Decoder

This block takes a stream of 12-bit conversion results from a single analog input wired to a chain of push-buttons and resistors, and turns it into a debounced button number. A different resistor is switched in by each button, so each button pulls the level to its own nominal code. Button k sits near `BASE + (k-1)*STEP`, which is 1000, 2000 and 3000 counts with the default values. With nothing pressed the level rests near full scale. On every sample strobe the block places the result in a class: one button window (nominal level ± `HALF` counts), the idle class (at or above `IDLE_MIN`), or an unknown class for anything between windows.

Each press must be confirmed. A button is reported only after `CONFIRM` consecutive strobed samples land in the same window. This rejects the brief passes through other windows that occur while the analog level slews from one value to another. When a press is confirmed, the block raises a held valid flag together with the button number, and pulses a press event for exactly one clock. The run counter saturates, so a long hold never produces a second event. A new event can only come after some other class has been seen in between.

The conversion timing, the sample-rate timer and any analog settling correction sit outside this block.

Top module: `adcb_ladder_decoder`

## Requirements
- R1: Synchronous active-high reset clears the run count, sets the remembered class to idle, and drives `btn_valid`, `btn_press` and `btn_idx` to 0. After reset, a full new run of `CONFIRM` samples is needed before any press.
- R2: A strobed sample is put in button k (1-based) when it lies within `BASE+(k-1)*STEP ± HALF`, with both bounds included. With the defaults, 950 and 1050 count as button 1 and 949 and 1051 do not. Two windows never both match.
- R3: A sample at or above `IDLE_MIN` (default 3900) is idle. It never produces a press, and it clears `btn_valid` and sets `btn_idx` to 0.
- R4: On the `CONFIRM`-th (default 5) consecutive strobe that falls in the same button window, `btn_press` is 1 and `btn_valid` is 1, and `btn_idx` holds the button number. These values appear in the clock cycle that follows the strobe edge. Before that strobe, `btn_valid` stays 0.
- R5: A sample that falls in no window and is below `IDLE_MIN` is unknown. It breaks any run, drives `btn_valid` to 0, and never produces a press.
- R6: `btn_press` lasts exactly one clock. While the same window keeps being hit, the count saturates: `btn_valid` stays 1 and no further press occurs, however long the hold lasts.
- R7: After a confirmed button, a sample in a different button window drops `btn_valid` at once. That other button is then confirmed after its own `CONFIRM` samples.
- R8: Clock cycles without a strobe change nothing: `btn_valid` and `btn_idx` hold whatever `smp_code` does.
- R9: A run that is interrupted in another button's window restarts from one. A press follows only after `CONFIRM` uninterrupted samples in the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One-cycle strobe marking a new conversion result |
| smp_code | input | 12 | Conversion result, 0..4095 |
| btn_idx | output | 4 | Confirmed button number (1..NUM_BTN), 0 when none |
| btn_valid | output | 1 | High while a confirmed button is held |
| btn_press | output | 1 | One-clock event when a button is first confirmed |

## Verification
The assertions assume that `smp_valid` is a single-cycle strobe that is synchronous to `clk`. They also assume `smp_code` is stable and known in every cycle that carries a strobe. The single-pulse check further relies on `CONFIRM` being at least two, which the elaboration guard enforces. The bench drives code and strobe on the falling edge and holds the strobe for one cycle only. It leaves at least one quiet cycle between strobes and reads the outputs on the following falling edge. Unstrobed codes are applied on purpose, and only in the stretch that checks that such codes have no effect.

// File: rtl/adcb_pkg.sv
package adcb_pkg;

    localparam int BTN_IDX_W = 4;
    localparam int MAX_BTN   = (1 << BTN_IDX_W) - 1;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_BTN  = 2'd1,
        K_UNK  = 2'd2
    } cls_kind_e;

    typedef struct packed {
        cls_kind_e             kind;
        logic [BTN_IDX_W-1:0]  idx;
    } cls_t;

    localparam cls_t CLS_IDLE = '{kind: K_NONE, idx: '0};
    localparam cls_t CLS_UNK  = '{kind: K_UNK,  idx: '0};

    function automatic int win_center(input int base, input int step, input int n);
        return base + n * step;
    endfunction

    function automatic int win_low(input int center, input int half);
        return center - half;
    endfunction

    function automatic int win_high(input int center, input int half);
        return center + half;
    endfunction

    function automatic logic cls_match(input cls_t a, input cls_t b);
        return (a.kind == b.kind) && (a.idx == b.idx);
    endfunction

endpackage

// File: rtl/adcb_window.sv
module adcb_window #(
    parameter int SAMPLE_W = 12,
    parameter int CENTER   = 1000,
    parameter int HALF     = 50
) (
    input  logic [SAMPLE_W-1:0] code,
    output logic                hit
);
    localparam int LO = adcb_pkg::win_low(CENTER, HALF);
    localparam int HI = adcb_pkg::win_high(CENTER, HALF);

    int code_i;

    always_comb begin
        code_i = int'(code);
        hit    = (code_i >= LO) && (code_i <= HI);
    end
endmodule

// File: rtl/adcb_classifier.sv
module adcb_classifier
    import adcb_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int NUM_BTN  = 3,
    parameter int BASE     = 1000,
    parameter int STEP     = 1000,
    parameter int HALF     = 50,
    parameter int IDLE_MIN = 3900
) (
    input  logic [SAMPLE_W-1:0] code,
    output logic [NUM_BTN-1:0]  hits,
    output cls_t                cls
);
    logic idle;

    for (genvar g = 0; g < NUM_BTN; g++) begin : g_win
        adcb_window #(
            .SAMPLE_W (SAMPLE_W),
            .CENTER   (win_center(BASE, STEP, g)),
            .HALF     (HALF)
        ) u_win (
            .code (code),
            .hit  (hits[g])
        );
    end

    assign idle = (int'(code) >= IDLE_MIN);

    always_comb begin
        cls = CLS_UNK;
        if (idle) begin
            cls = CLS_IDLE;
        end
        for (int i = 0; i < NUM_BTN; i++) begin
            if (hits[i]) begin
                cls.kind = K_BTN;
                cls.idx  = BTN_IDX_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/adcb_run_tracker.sv
module adcb_run_tracker
    import adcb_pkg::*;
#(
    parameter int CONFIRM = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe,
    input  cls_t                 cls,
    output logic                 valid_o,
    output logic                 press_o,
    output logic [BTN_IDX_W-1:0] idx_o
);
    localparam int              CNT_W = $clog2(CONFIRM + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CONFIRM);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    cls_t             last_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             same;
    logic             reached;
    logic             was_full;

    always_comb begin
        same     = cls_match(cls, last_q);
        was_full = same && (cnt_q == FULL);
        if (!same) begin
            cnt_d = (cls.kind == K_BTN) ? ONE : '0;
        end else if ((cls.kind == K_BTN) && (cnt_q != FULL)) begin
            cnt_d = cnt_q + ONE;
        end else begin
            cnt_d = cnt_q;
        end
        reached = (cls.kind == K_BTN) && (cnt_d == FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= CLS_IDLE;
            cnt_q   <= '0;
            valid_o <= 1'b0;
            press_o <= 1'b0;
            idx_o   <= '0;
        end else begin
            press_o <= 1'b0;
            if (strobe) begin
                last_q  <= cls;
                cnt_q   <= cnt_d;
                valid_o <= reached;
                press_o <= reached && !was_full;
                idx_o   <= reached ? cls.idx : '0;
            end
        end
    end

    // R1: reset leaves every output quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!valid_o && !press_o && (idx_o == '0)));

    // R4: an event is always accompanied by a held valid
    p_press_with_valid_r4: assert property (@(posedge clk) disable iff (rst)
        press_o |-> (valid_o && (idx_o != '0)));

    // R6: event never lasts two clocks
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        press_o |=> !press_o);

    // R6: run count never exceeds the confirm threshold
    p_cnt_cap_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

    // R5 / R3: idle or unknown samples end any valid state
    p_nonbutton_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (strobe && (cls.kind != K_BTN)) |=> (!valid_o && !press_o));

    // R8: quiet cycles leave the reported state alone
    p_hold_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> ($stable(valid_o) && $stable(idx_o) && !press_o));
endmodule

// File: rtl/adcb_ladder_decoder.sv
module adcb_ladder_decoder
    import adcb_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int NUM_BTN  = 3,
    parameter int BASE     = 1000,
    parameter int STEP     = 1000,
    parameter int HALF     = 50,
    parameter int IDLE_MIN = 3900,
    parameter int CONFIRM  = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  logic [SAMPLE_W-1:0]  smp_code,
    output logic [BTN_IDX_W-1:0] btn_idx,
    output logic                 btn_valid,
    output logic                 btn_press
);
    localparam int FULL_SCALE = (1 << SAMPLE_W) - 1;
    localparam int TOP_HIGH   = win_high(win_center(BASE, STEP, NUM_BTN - 1), HALF);
    localparam int BOT_LOW    = win_low(BASE, HALF);

    if (NUM_BTN < 1 || NUM_BTN > MAX_BTN) begin : g_bad_count
        $error("button count out of range");
    end
    if (STEP <= 2 * HALF) begin : g_bad_overlap
        $error("adjacent windows overlap");
    end
    if (BOT_LOW < 0) begin : g_bad_low
        $error("lowest window below zero");
    end
    if (TOP_HIGH >= IDLE_MIN) begin : g_bad_idle
        $error("highest window reaches idle region");
    end
    if (IDLE_MIN > FULL_SCALE) begin : g_bad_scale
        $error("idle threshold beyond full scale");
    end
    if (CONFIRM < 2) begin : g_bad_confirm
        $error("confirm count must be at least two");
    end

    logic [NUM_BTN-1:0] hits;
    cls_t               cls;

    adcb_classifier #(
        .SAMPLE_W (SAMPLE_W),
        .NUM_BTN  (NUM_BTN),
        .BASE     (BASE),
        .STEP     (STEP),
        .HALF     (HALF),
        .IDLE_MIN (IDLE_MIN)
    ) u_cls (
        .code (smp_code),
        .hits (hits),
        .cls  (cls)
    );

    adcb_run_tracker #(
        .CONFIRM (CONFIRM)
    ) u_run (
        .clk     (clk),
        .rst     (rst),
        .strobe  (smp_valid),
        .cls     (cls),
        .valid_o (btn_valid),
        .press_o (btn_press),
        .idx_o   (btn_idx)
    );

    // R2: a strobed code never matches two windows
    p_windows_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> $onehot0(hits));

    // R2: a button class always carries an in-range number
    p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && (cls.kind == K_BTN)) |-> ((cls.idx >= 1) && (int'(cls.idx) <= NUM_BTN)));
endmodule

// File: tb/adcb_ladder_decoder_bench.sv
module adcb_ladder_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_code = 12'd4095;
    logic [3:0]  btn_idx;
    logic        btn_valid;
    logic        btn_press;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adcb_ladder_decoder u_adcb_ladder_decoder (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_code  (smp_code),
        .btn_idx   (btn_idx),
        .btn_valid (btn_valid),
        .btn_press (btn_press)
    );

    task automatic expect_out(input string req, input bit ep, input bit ev, input int ei);
        checks++;
        if (btn_press !== ep || btn_valid !== ev || int'(btn_idx) != ei) begin
            errors++;
            $display("FAIL %s: press/valid/idx got %b/%b/%0d expected %b/%b/%0d",
                     req, btn_press, btn_valid, btn_idx, ep, ev, ei);
        end
    endtask

    task automatic send(input int code);
        @(negedge clk);
        smp_code  = 12'(code);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic send_n(input int code, input int n, input string req, input int ei);
        for (int i = 1; i <= n; i++) begin
            send(code);
            if (i < 5) expect_out(req, 1'b0, 1'b0, 0);
            else       expect_out(req, (i == 5), 1'b1, ei);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        expect_out("R1 reset state", 1'b0, 1'b0, 0);
    endtask

    task automatic t_confirm();
        send_n(1000, 5, "R4 confirm", 1);
        @(negedge clk);
        expect_out("R6 pulse one clock", 1'b0, 1'b1, 1);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 20; i++) begin
            send((i % 2 == 0) ? 960 : 1040);
            expect_out("R6 long hold no repeat", 1'b0, 1'b1, 1);
        end
    endtask

    task automatic t_release();
        send(4095);
        expect_out("R3 idle clears valid", 1'b0, 1'b0, 0);
        for (int i = 0; i < 8; i++) begin
            send(3900 + i * 20);
            expect_out("R3 idle never presses", 1'b0, 1'b0, 0);
        end
    endtask

    task automatic t_edges();
        send_n(950, 5, "R2 low bound", 1);
        send(4095);
        send_n(1050, 5, "R2 high bound", 1);
        send(4095);
        for (int i = 0; i < 6; i++) begin
            send(949);
            expect_out("R2 below low bound", 1'b0, 1'b0, 0);
        end
        for (int i = 0; i < 6; i++) begin
            send(1051);
            expect_out("R2 above high bound", 1'b0, 1'b0, 0);
        end
        send_n(2050, 5, "R2 second window", 2);
        send(4095);
    endtask

    task automatic t_unknown();
        for (int i = 0; i < 4; i++) send(1000);
        expect_out("R5 before break", 1'b0, 1'b0, 0);
        send(1500);
        expect_out("R5 unknown sample", 1'b0, 1'b0, 0);
        for (int i = 0; i < 4; i++) begin
            send(1000);
            expect_out("R5 run restarted", 1'b0, 1'b0, 0);
        end
        send(1000);
        expect_out("R5 confirm after restart", 1'b1, 1'b1, 1);
        send(2500);
        expect_out("R5 unknown clears valid", 1'b0, 1'b0, 0);
        send(4095);
    endtask

    task automatic t_switch();
        for (int i = 0; i < 3; i++) send(3000);
        send_n(2000, 5, "R9 switched run", 2);
        send(3000);
        expect_out("R7 other window drops valid", 1'b0, 1'b0, 0);
        for (int i = 0; i < 3; i++) send(3000);
        expect_out("R7 not yet confirmed", 1'b0, 1'b0, 0);
        send(3000);
        expect_out("R7 new button confirmed", 1'b1, 1'b1, 3);
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        smp_code = 12'd1500;
        repeat (6) @(negedge clk);
        expect_out("R8 unknown code unstrobed", 1'b0, 1'b1, 3);
        smp_code = 12'd4095;
        repeat (6) @(negedge clk);
        expect_out("R8 idle code unstrobed", 1'b0, 1'b1, 3);
        smp_code = 12'd1000;
        repeat (6) @(negedge clk);
        expect_out("R8 other button unstrobed", 1'b0, 1'b1, 3);
    endtask

    task automatic t_reset_mid_run();
        send(4095);
        for (int i = 0; i < 4; i++) send(1000);
        do_reset();
        expect_out("R1 reset mid run", 1'b0, 1'b0, 0);
        send_n(1000, 5, "R1 full run after reset", 1);
    endtask

    initial begin
        t_reset();
        t_confirm();
        t_hold();
        t_release();
        t_edges();
        t_unknown();
        t_switch();
        t_no_strobe();
        t_reset_mid_run();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule